// File: doc/BRIEF.md
# AXI ID Filtered Traffic Counter

This block sits beside a memory controller's AXI slave port and turns address-channel handshakes into filtered traffic events for a bank of performance counters. It holds one filter register with an ID value and a significance mask. That single setting is shared by both address channels and by every counter. Each accepted read address (AR handshake) or write address (AW handshake) whose transaction ID matches the filter produces a one-cycle event pulse. The pulse goes to the counter bank, which is outside this block.

When enhanced mode is on, the block also keeps one byte register per counter. A counter programmed with the matched-read code gains the byte size of every matching read burst. A counter programmed with the matched-write code does the same for matching write bursts. Counters with any other code are not touched. Burst size is computed from the length and size fields of the address channel. Accumulation pauses while the counter bank freezes, and a counter clear also empties its byte register.

Top module: `axid_traffic_filter`

## Requirements
- R1: After reset both event outputs are low, every byte register reads zero, and the filter ID and stored mask are zero, so every ID matches.
- R2: A write on the filter port stores wdata bits [ID_W-1:0] as the ID and bits [16+ID_W-1:16] as the stored mask. Software writes the mask in complemented form, so a stored bit of 1 marks a compared position. A handshake in the same cycle as the write still uses the previous setting; the new setting applies from the next cycle.
- R3: A transaction ID matches when ((id XOR filter_id) AND stored_mask) is zero. A stored mask of all zeros matches every ID.
- R4: rd_evt is high for exactly one cycle, in the cycle after each AR handshake (arvalid and arready both high) with a matching arid. arvalid without arready gives no pulse.
- R5: wr_evt behaves the same way for AW handshakes with a matching awid.
- R6: In enhanced mode, a counter whose 8-bit event code is 8'h41 adds (arlen+1) << arsize for each matching AR handshake. A counter with code 8'h42 adds (awlen+1) << awsize for each matching AW handshake. The result appears one cycle after the handshake, modulo 2^CNT_W.
- R7: A counter whose code is neither 8'h41 nor 8'h42 never changes its byte register, except when it is cleared.
- R8: With enhanced mode off, no byte register changes, except when it is cleared.
- R9: While freeze is high, no byte register changes, except when it is cleared.
- R10: cnt_clr[n] zeroes byte register n in the next cycle, even when an add would happen in the same cycle.
- R11: Reads and writes are compared against the same single filter setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| filt_we | input | 1 | Filter register write strobe |
| filt_wdata | input | 32 | Filter write data: ID in the low half, stored mask in the high half |
| enh_en | input | 1 | Enhanced (byte counting) mode |
| freeze | input | 1 | Counter bank freeze; pauses accumulation |
| cnt_clr | input | NUM_CNT | Per-counter clear |
| cnt_code | input | NUM_CNT*8 | Event code of each counter, 8 bits each, counter 0 lowest |
| arvalid | input | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| arid | input | ID_W | Read transaction ID |
| arlen | input | LEN_W | Read burst length minus one |
| arsize | input | SIZE_W | Read beat size, log2 bytes |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awid | input | ID_W | Write transaction ID |
| awlen | input | LEN_W | Write burst length minus one |
| awsize | input | SIZE_W | Write beat size, log2 bytes |
| rd_evt | output | 1 | Matched read burst pulse |
| wr_evt | output | 1 | Matched write burst pulse |
| byte_cnt | output | NUM_CNT*CNT_W | Byte registers, CNT_W bits each, counter 0 lowest |

## Verification
The bench builds the block with ID_W=4, NUM_CNT=3 and CNT_W=16. The narrow ID makes it possible to sweep every ID on both channels under several masks and filter IDs. The 16-bit byte registers wrap after two maximal bursts of 32768 bytes, so wraparound can be checked. The three counters are coded for matched reads, matched writes and an unfiltered event, so every accumulation path is compared against the bench's own arithmetic model after each handshake.

// File: rtl/axf_pkg.sv
package axf_pkg;
    localparam int         FILT_MASK_LSB = 16;
    localparam logic [7:0] EVC_RD_MATCH  = 8'h41;
    localparam logic [7:0] EVC_WR_MATCH  = 8'h42;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RD   = 2'd1,
        SRC_WR   = 2'd2
    } acc_src_e;
endpackage

// File: rtl/axf_id_match.sv
module axf_id_match #(
    parameter int ID_W = 16
) (
    input  logic [ID_W-1:0] id_i,
    input  logic [ID_W-1:0] ref_id_i,
    input  logic [ID_W-1:0] mask_i,
    output logic            hit_o
);
    always_comb begin
        hit_o = (((id_i ^ ref_id_i) & mask_i) == '0);
    end
endmodule

// File: rtl/axf_byte_acc.sv
module axf_byte_acc
    import axf_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             freeze_i,
    input  logic             enh_i,
    input  logic [7:0]       code_i,
    input  logic             rd_fire_i,
    input  logic             wr_fire_i,
    input  logic [CNT_W-1:0] rd_add_i,
    input  logic [CNT_W-1:0] wr_add_i,
    output logic [CNT_W-1:0] cnt_o
);
    acc_src_e         src;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        unique case (code_i)
            EVC_RD_MATCH: src = SRC_RD;
            EVC_WR_MATCH: src = SRC_WR;
            default:      src = SRC_NONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (enh_i && !freeze_i) begin
            unique case (src)
                SRC_RD:  if (rd_fire_i) cnt_q <= cnt_q + rd_add_i;
                SRC_WR:  if (wr_fire_i) cnt_q <= cnt_q + wr_add_i;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/axid_traffic_filter.sv
module axid_traffic_filter
    import axf_pkg::*;
#(
    parameter int ID_W    = 16,
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32,
    parameter int LEN_W   = 8,
    parameter int SIZE_W  = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     filt_we,
    input  logic [31:0]              filt_wdata,
    input  logic                     enh_en,
    input  logic                     freeze,
    input  logic [NUM_CNT-1:0]       cnt_clr,
    input  logic [NUM_CNT*8-1:0]     cnt_code,
    input  logic                     arvalid,
    input  logic                     arready,
    input  logic [ID_W-1:0]          arid,
    input  logic [LEN_W-1:0]         arlen,
    input  logic [SIZE_W-1:0]        arsize,
    input  logic                     awvalid,
    input  logic                     awready,
    input  logic [ID_W-1:0]          awid,
    input  logic [LEN_W-1:0]         awlen,
    input  logic [SIZE_W-1:0]        awsize,
    output logic                     rd_evt,
    output logic                     wr_evt,
    output logic [NUM_CNT*CNT_W-1:0] byte_cnt
);
    localparam int BYTES_W = LEN_W + (1 << SIZE_W);

    logic [ID_W-1:0]    filt_id_q;
    logic [ID_W-1:0]    filt_mask_q;
    logic               rd_hit, wr_hit;
    logic               rd_fire, wr_fire;
    logic               rd_evt_q, wr_evt_q;
    logic [BYTES_W-1:0] rd_beats, wr_beats;
    logic [BYTES_W-1:0] rd_bytes, wr_bytes;
    logic [CNT_W-1:0]   rd_add, wr_add;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_id_q   <= '0;
            filt_mask_q <= '0;
        end else if (filt_we) begin
            filt_id_q   <= filt_wdata[ID_W-1:0];
            filt_mask_q <= filt_wdata[FILT_MASK_LSB +: ID_W];
        end
    end

    axf_id_match #(.ID_W(ID_W)) u_rd_match (
        .id_i     (arid),
        .ref_id_i (filt_id_q),
        .mask_i   (filt_mask_q),
        .hit_o    (rd_hit)
    );

    axf_id_match #(.ID_W(ID_W)) u_wr_match (
        .id_i     (awid),
        .ref_id_i (filt_id_q),
        .mask_i   (filt_mask_q),
        .hit_o    (wr_hit)
    );

    always_comb begin
        rd_fire  = arvalid && arready && rd_hit;
        wr_fire  = awvalid && awready && wr_hit;
        rd_beats = BYTES_W'(arlen) + BYTES_W'(1);
        wr_beats = BYTES_W'(awlen) + BYTES_W'(1);
        rd_bytes = rd_beats << arsize;
        wr_bytes = wr_beats << awsize;
        rd_add   = CNT_W'(rd_bytes);
        wr_add   = CNT_W'(wr_bytes);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_evt_q <= 1'b0;
            wr_evt_q <= 1'b0;
        end else begin
            rd_evt_q <= rd_fire;
            wr_evt_q <= wr_fire;
        end
    end

    assign rd_evt = rd_evt_q;
    assign wr_evt = wr_evt_q;

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_acc
        axf_byte_acc #(.CNT_W(CNT_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (cnt_clr[n]),
            .freeze_i  (freeze),
            .enh_i     (enh_en),
            .code_i    (cnt_code[n*8 +: 8]),
            .rd_fire_i (rd_fire),
            .wr_fire_i (wr_fire),
            .rd_add_i  (rd_add),
            .wr_add_i  (wr_add),
            .cnt_o     (byte_cnt[n*CNT_W +: CNT_W])
        );
    end
endmodule

// File: rtl/axf_filter_chk.sv
module axf_filter_chk
    import axf_pkg::*;
#(
    parameter int ID_W    = 16,
    parameter int NUM_CNT = 4,
    parameter int CNT_W   = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     enh_en,
    input logic                     freeze,
    input logic [NUM_CNT-1:0]       cnt_clr,
    input logic [NUM_CNT*8-1:0]     cnt_code,
    input logic                     arvalid,
    input logic                     arready,
    input logic                     awvalid,
    input logic                     awready,
    input logic [ID_W-1:0]          filt_mask_q,
    input logic                     rd_evt,
    input logic                     wr_evt,
    input logic [NUM_CNT*CNT_W-1:0] byte_cnt
);
    a_r4_no_rd_without_hs: assert property (@(posedge clk) disable iff (!rst_n)
        !(arvalid && arready) |=> !rd_evt);

    a_r5_no_wr_without_hs: assert property (@(posedge clk) disable iff (!rst_n)
        !(awvalid && awready) |=> !wr_evt);

    a_r11_open_filter_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_mask_q == '0 && arvalid && arready) |=> rd_evt);

    a_r11_open_filter_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_mask_q == '0 && awvalid && awready) |=> wr_evt);

    for (genvar n = 0; n < NUM_CNT; n++) begin : g_cnt
        a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_clr[n] |=> byte_cnt[n*CNT_W +: CNT_W] == '0);

        a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze && !cnt_clr[n]) |=> $stable(byte_cnt[n*CNT_W +: CNT_W]));

        a_r8_enh_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!enh_en && !cnt_clr[n]) |=> $stable(byte_cnt[n*CNT_W +: CNT_W]));

        a_r7_unfiltered_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_code[n*8 +: 8] != EVC_RD_MATCH && cnt_code[n*8 +: 8] != EVC_WR_MATCH
             && !cnt_clr[n]) |=> $stable(byte_cnt[n*CNT_W +: CNT_W]));
    end
endmodule

bind axid_traffic_filter axf_filter_chk #(
    .ID_W    (ID_W),
    .NUM_CNT (NUM_CNT),
    .CNT_W   (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enh_en      (enh_en),
    .freeze      (freeze),
    .cnt_clr     (cnt_clr),
    .cnt_code    (cnt_code),
    .arvalid     (arvalid),
    .arready     (arready),
    .awvalid     (awvalid),
    .awready     (awready),
    .filt_mask_q (filt_mask_q),
    .rd_evt      (rd_evt),
    .wr_evt      (wr_evt),
    .byte_cnt    (byte_cnt)
);

// File: tb/tb_axid_traffic_filter.sv
`timescale 1ns/1ps
module tb_axid_traffic_filter;
    localparam int ID_W = 4, NUM_CNT = 3, CNT_W = 16, LEN_W = 8, SIZE_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic filt_we = 1'b0;
    logic [31:0] filt_wdata = '0;
    logic enh_en = 1'b0, freeze = 1'b0;
    logic [NUM_CNT-1:0] cnt_clr = '0;
    logic [NUM_CNT*8-1:0] cnt_code = {8'h04, 8'h42, 8'h41};
    logic arvalid = 1'b0, arready = 1'b0, awvalid = 1'b0, awready = 1'b0;
    logic [ID_W-1:0] arid = '0, awid = '0;
    logic [LEN_W-1:0] arlen = '0, awlen = '0;
    logic [SIZE_W-1:0] arsize = '0, awsize = '0;
    logic rd_evt, wr_evt;
    logic [NUM_CNT*CNT_W-1:0] byte_cnt;

    int n_chk = 0, n_fail = 0;
    int fid = 0, fmask = 0;
    int exp_b [NUM_CNT];
    bit done = 1'b0;

    always #5 clk = ~clk;

    axid_traffic_filter #(.ID_W(ID_W), .NUM_CNT(NUM_CNT), .CNT_W(CNT_W),
                          .LEN_W(LEN_W), .SIZE_W(SIZE_W)) dut (.*);

    task automatic chk(input int got, input int exp, input string tag);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic bit id_match(input int id);
        return ((id ^ fid) & fmask & 'hF) == 0;
    endfunction

    task automatic chk_counts(input string tag);
        for (int i = 0; i < NUM_CNT; i++)
            chk(int'(byte_cnt[i*CNT_W +: CNT_W]), exp_b[i], tag);
    endtask

    // Called at a negedge: one handshake attempt on one channel, checked at the next negedge.
    task automatic do_hs(input bit wr, input int id, input int len, input int sz,
                         input bit rdy, input string tag);
        bit fire;
        int bytes;
        if (wr) begin
            awvalid = 1'b1; awready = rdy; awid = ID_W'(id);
            awlen = LEN_W'(len); awsize = SIZE_W'(sz);
        end else begin
            arvalid = 1'b1; arready = rdy; arid = ID_W'(id);
            arlen = LEN_W'(len); arsize = SIZE_W'(sz);
        end
        fire  = rdy && id_match(id);
        bytes = ((len & 'hFF) + 1) << (sz & 7);
        for (int i = 0; i < NUM_CNT; i++) begin
            if (cnt_clr[i]) exp_b[i] = 0;
            else if (enh_en && !freeze && fire &&
                     cnt_code[i*8 +: 8] == (wr ? 8'h42 : 8'h41))
                exp_b[i] = (exp_b[i] + bytes) & 'hFFFF;
        end
        @(negedge clk);
        if (filt_we) begin
            fid = int'(filt_wdata[3:0]); fmask = int'(filt_wdata[19:16]);
            filt_we = 1'b0;
        end
        chk(wr ? int'(wr_evt) : int'(rd_evt), int'(fire), tag);
        chk(wr ? int'(rd_evt) : int'(wr_evt), 0, "R11 other channel quiet");
        chk_counts(tag);
        arvalid = 1'b0; arready = 1'b0; awvalid = 1'b0; awready = 1'b0;
        cnt_clr = '0;
        @(negedge clk);
        chk(int'(rd_evt) + int'(wr_evt), 0, "R4 R5 single cycle pulse");
    endtask

    task automatic set_filter(input int id, input int mask);
        filt_we = 1'b1;
        filt_wdata = {12'h0, 4'(mask), 12'h0, 4'(id)};
        @(negedge clk);
        filt_we = 1'b0;
        fid = id; fmask = mask;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int masks [5] = '{0, 'hF, 'h5, 'hA, 'h8};
        for (int i = 0; i < NUM_CNT; i++) exp_b[i] = 0;
        repeat (3) @(negedge clk);
        chk(int'(rd_evt) + int'(wr_evt), 0, "R1 events low in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_counts("R1 counts zero after reset");
        // R1/R3: reset filter matches every ID
        do_hs(1'b0, 9, 0, 0, 1'b1, "R1 reset filter matches all");
        do_hs(1'b1, 6, 0, 0, 1'b1, "R1 reset filter matches all");
        // R8: enhanced off, no bytes
        do_hs(1'b0, 3, 7, 2, 1'b1, "R8 enhanced off holds");
        enh_en = 1'b1;
        // R2 R3 R4 R5 R6 R11: exhaustive ID sweep
        for (int m = 0; m < 5; m++) begin
            set_filter(6 + m, masks[m]);
            for (int id = 0; id < 16; id++) begin
                do_hs(1'b0, id, id * 3 + m, id % 8, 1'b1, "R3 R4 R6 read match");
                do_hs(1'b1, id, id * 5 + m, (id + m) % 8, 1'b1, "R3 R5 R6 write match");
            end
        end
        // R4 R5: valid without ready
        set_filter(0, 0);
        do_hs(1'b0, 1, 4, 1, 1'b0, "R4 no ready no pulse");
        do_hs(1'b1, 1, 4, 1, 1'b0, "R5 no ready no pulse");
        // R2: filter write in same cycle as handshake uses old filter
        filt_we = 1'b1; filt_wdata = {12'h0, 4'hF, 12'h0, 4'h2};
        do_hs(1'b0, 5, 1, 1, 1'b1, "R2 old filter same cycle");
        do_hs(1'b0, 5, 1, 1, 1'b1, "R2 new filter next cycle");
        do_hs(1'b1, 2, 1, 1, 1'b1, "R11 shared filter write");
        // R10: clear with concurrent add
        set_filter(0, 0);
        cnt_clr = 3'b011;
        do_hs(1'b0, 4, 10, 3, 1'b1, "R10 clear beats add");
        // R6: wraparound of 16-bit register
        do_hs(1'b0, 0, 255, 7, 1'b1, "R6 wrap first burst");
        do_hs(1'b0, 0, 255, 7, 1'b1, "R6 wrap to zero");
        do_hs(1'b0, 0, 255, 7, 1'b1, "R6 wrap continue");
        // R9: freeze holds
        freeze = 1'b1;
        do_hs(1'b0, 2, 3, 3, 1'b1, "R9 freeze read");
        do_hs(1'b1, 2, 3, 3, 1'b1, "R9 freeze write");
        cnt_clr = 3'b100;
        do_hs(1'b1, 2, 3, 3, 1'b1, "R10 clear under freeze");
        freeze = 1'b0;
        // R7: counter 2 holds an unfiltered code
        do_hs(1'b1, 7, 9, 4, 1'b1, "R7 unfiltered code holds");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule